// File: doc/BRIEF.md
# Lockstep Majority Voter with Spare Substitution

This block sits behind a group of identical compute units that run the same work in lockstep. Each cycle it takes the result bus of every unit that currently belongs to the voting set. It forms a bitwise majority over those results and registers it as the voted output. Units that are not in the voting set are ignored.

When the vote is clean, any voting unit whose result differs from the majority is treated as corrupt. It is pulled out of the voting set, and its reset line is pulsed for a fixed number of cycles. It is then retired. Its place is taken by the lowest-numbered unused spare. Once the spare pool is empty, a failing unit is simply dropped and a sticky degraded flag is raised. An alarm is raised whenever fewer than three units are still voting, because below that count a single fault can no longer be outvoted.

The physical unit count, the size of the initial voting set, the result width and the reset pulse length are all parameters. By default there are six units, four of which vote at first, so two are spares. Results are 8 bits wide and the reset pulse lasts 4 cycles.

Top module: `lockstep_voter`

## Requirements
- R1: After reset, active_map has bits 0..NUM_VOTE-1 set and all others clear. voted_result is 0, and voted_valid, no_majority, unit_reset, degraded and alarm are all 0.
- R2: When every voting unit presents valid, voted_result takes, one clock edge later, the bitwise majority over the voting units' results, and voted_valid is 1. Without a vote, voted_result holds its last value.
- R3: If any voting unit has its valid low, no vote is taken: voted_valid is 0 the next cycle and active_map does not change. Results and valid bits of units outside active_map have no effect.
- R4: If on any bit exactly half of the voting units hold 1, no_majority is 1 for that vote and no unit is removed.
- R5: When a clean vote is taken (no tie), every voting unit whose result differs from the voted value leaves active_map at the same edge. Its unit_reset bit is then 1 for exactly RST_CYCLES cycles.
- R6: For each removed unit, one unused spare joins active_map at the same edge. Spares are taken in ascending index order, one per removed unit.
- R7: A unit that has left active_map never rejoins it until the next reset.
- R8: If more units are removed than spares remain, the surplus units are dropped. degraded becomes 1 and stays 1 until reset.
- R9: alarm is 1 exactly when fewer than three bits of active_map are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_result | input | NUM_UNITS*DATA_W | Result buses; unit u occupies bits u*DATA_W +: DATA_W |
| unit_valid | input | NUM_UNITS | Per-unit result valid |
| voted_result | output | DATA_W | Registered majority result |
| voted_valid | output | 1 | A vote was taken on the previous cycle's inputs |
| no_majority | output | 1 | The last vote had a tie on at least one bit |
| unit_reset | output | NUM_UNITS | Per-unit reset pulse for removed units |
| active_map | output | NUM_UNITS | Units currently in the voting set |
| degraded | output | 1 | Sticky: a failed unit could not be replaced |
| alarm | output | 1 | Fewer than three units voting |

## Verification
The main function is exercised with results that all agree, which checks the majority path alone. A single outlier with three agreeing units shows removal, the reset pulse and spare substitution working together. Two units that are wrong on different bits still give a clean vote, yet both are removed in one cycle; with only one spare left, this separates ascending spare allocation from the degraded path. Exact splits, on one bit and on all bits, check that a tie blocks any reconfiguration. Cycles with a voting unit's valid low, and garbage driven on retired units, show that neither a withheld vote nor an inactive input changes state.

// File: rtl/lockstep_voter_pkg.sv
package lockstep_voter_pkg;
  // Smallest voting set in which one faulty unit is still outvoted.
  localparam int unsigned QUORUM_MIN = 3;
endpackage

// File: rtl/lv_majority.sv
module lv_majority #(
  parameter int unsigned NUM_UNITS = 6,
  parameter int unsigned DATA_W    = 8
) (
  input  logic [NUM_UNITS*DATA_W-1:0] results,
  input  logic [NUM_UNITS-1:0]        active,
  output logic [DATA_W-1:0]           maj,
  output logic                        tie,
  output logic [NUM_UNITS-1:0]        mismatch
);
  localparam int unsigned CNT_W = $clog2(NUM_UNITS + 1);

  logic [CNT_W:0] n_act;
  assign n_act = (CNT_W+1)'($countones(active));

  always_comb begin
    logic [CNT_W:0] ones;
    maj = '0;
    tie = 1'b0;
    for (int b = 0; b < DATA_W; b++) begin
      ones = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (active[u]) ones = ones + {{CNT_W{1'b0}}, results[u*DATA_W+b]};
      end
      maj[b] = (ones << 1) > n_act;
      if ((ones << 1) == n_act) tie = 1'b1;
    end
  end

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      mismatch[u] = active[u] && (results[u*DATA_W +: DATA_W] != maj);
    end
  end
endmodule

// File: rtl/lv_spare_alloc.sv
module lv_spare_alloc #(
  parameter int unsigned NUM_UNITS = 6
) (
  input  logic [NUM_UNITS-1:0] spare,
  input  logic [NUM_UNITS-1:0] losers,
  output logic [NUM_UNITS-1:0] grant,
  output logic                 shortfall
);
  localparam int unsigned CNT_W = $clog2(NUM_UNITS + 1);

  always_comb begin
    logic [CNT_W-1:0] need;
    need  = CNT_W'($countones(losers));
    grant = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (spare[i] && need != '0) begin
        grant[i] = 1'b1;
        need     = need - 1'b1;
      end
    end
    shortfall = (need != '0);
  end
endmodule

// File: rtl/lv_reset_timer.sv
module lv_reset_timer #(
  parameter int unsigned NUM_UNITS  = 6,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] load,
  output logic [NUM_UNITS-1:0] busy
);
  localparam int unsigned TW = $clog2(RST_CYCLES + 1);

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_tmr
    logic [TW-1:0] cnt_q, cnt_d;
    logic          cnt_en;

    always_comb begin
      cnt_en = load[g] || (cnt_q != '0);
      cnt_d  = load[g] ? TW'(RST_CYCLES) : cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign busy[g] = (cnt_q != '0);
  end
endmodule

// File: rtl/lockstep_voter.sv
module lockstep_voter #(
  parameter int unsigned NUM_UNITS  = 6,
  parameter int unsigned NUM_VOTE   = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_UNITS*DATA_W-1:0] unit_result,
  input  logic [NUM_UNITS-1:0]        unit_valid,
  output logic [DATA_W-1:0]           voted_result,
  output logic                        voted_valid,
  output logic                        no_majority,
  output logic [NUM_UNITS-1:0]        unit_reset,
  output logic [NUM_UNITS-1:0]        active_map,
  output logic                        degraded,
  output logic                        alarm
);
  import lockstep_voter_pkg::*;

  localparam logic [NUM_UNITS-1:0] INIT_ACTIVE = NUM_UNITS'((64'd1 << NUM_VOTE) - 64'd1);
  localparam logic [NUM_UNITS-1:0] INIT_SPARE  = ~INIT_ACTIVE;

  logic [NUM_UNITS-1:0] active_q, active_d, spare_q, spare_d;
  logic [DATA_W-1:0]    voted_q;
  logic                 vvalid_q, vvalid_d, nomaj_q, nomaj_d, degr_q, degr_d;

  logic [DATA_W-1:0]    maj;
  logic                 tie, vote_en, reconfig, shortfall;
  logic [NUM_UNITS-1:0] mismatch, losers, grant;

  lv_majority #(.NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W)) u_maj (
    .results (unit_result),
    .active  (active_q),
    .maj     (maj),
    .tie     (tie),
    .mismatch(mismatch)
  );

  lv_spare_alloc #(.NUM_UNITS(NUM_UNITS)) u_alloc (
    .spare    (spare_q),
    .losers   (losers),
    .grant    (grant),
    .shortfall(shortfall)
  );

  lv_reset_timer #(.NUM_UNITS(NUM_UNITS), .RST_CYCLES(RST_CYCLES)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (losers),
    .busy (unit_reset)
  );

  // Next-state logic
  always_comb begin
    vote_en  = (active_q != '0) && ((unit_valid | ~active_q) == '1);
    reconfig = vote_en && !tie;
    losers   = reconfig ? mismatch : '0;
    active_d = (active_q & ~losers) | grant;
    spare_d  = spare_q & ~grant;
    vvalid_d = vote_en;
    nomaj_d  = vote_en && tie;
    degr_d   = degr_q || (reconfig && shortfall);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= INIT_ACTIVE;
      spare_q  <= INIT_SPARE;
      vvalid_q <= 1'b0;
      nomaj_q  <= 1'b0;
      degr_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      spare_q  <= spare_d;
      vvalid_q <= vvalid_d;
      nomaj_q  <= nomaj_d;
      degr_q   <= degr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       voted_q <= '0;
    else if (vote_en) voted_q <= maj;
  end

  assign voted_result = voted_q;
  assign voted_valid  = vvalid_q;
  assign no_majority  = nomaj_q;
  assign active_map   = active_q;
  assign degraded     = degr_q;
  assign alarm        = $countones(active_q) < QUORUM_MIN;
endmodule

// File: rtl/lockstep_voter_chk.sv
module lockstep_voter_chk #(
  parameter int unsigned NUM_UNITS = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 voted_valid,
  input logic                 no_majority,
  input logic [NUM_UNITS-1:0] unit_reset,
  input logic [NUM_UNITS-1:0] active_map,
  input logic                 degraded,
  input logic                 alarm
);
  // R3: no vote taken means the voting set is untouched
  p_hold_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !voted_valid |-> $stable(active_map));

  // R4: a tie never reconfigures
  p_tie_keeps_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    no_majority |-> (voted_valid && $stable(active_map)));

  // R6: substitution never grows the voting set
  p_no_growth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active_map) <= $past($countones(active_map)));

  // R8: degraded is sticky
  p_degraded_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    degraded |=> degraded);

  // R9: too few voters raises the alarm
  p_alarm_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(active_map) < 3) |-> alarm);

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    // R5: a unit under reset is not voting
    p_reset_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      unit_reset[g] |-> !active_map[g]);
    // R7: a removed unit stays out
    p_stays_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_map[g]) |=> !active_map[g]);
  end
endmodule

bind lockstep_voter lockstep_voter_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .voted_valid(voted_valid),
  .no_majority(no_majority),
  .unit_reset (unit_reset),
  .active_map (active_map),
  .degraded   (degraded),
  .alarm      (alarm)
);

// File: tb/lockstep_voter_test.sv
`timescale 1ns/100ps
module lockstep_voter_test;
  localparam int N   = 6;
  localparam int V   = 4;
  localparam int W   = 8;
  localparam int RST = 4;

  typedef struct {
    logic [W-1:0] voted;
    logic         vvalid;
    logic         nomaj;
    logic [N-1:0] act;
    logic [N-1:0] rst;
    logic         degr;
    logic         alarm;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N*W-1:0] unit_result;
  logic [N-1:0]   unit_valid;
  logic [W-1:0]   voted_result;
  logic           voted_valid, no_majority, degraded, alarm;
  logic [N-1:0]   unit_reset, active_map;

  int errors = 0;
  int checks = 0;
  exp_t sb[$];

  // bench reference state
  logic [N-1:0] m_act, m_spare;
  logic [W-1:0] m_voted;
  logic         m_degr;
  int           m_cnt[N];

  always #2.5 clk = ~clk;

  lockstep_voter #(.NUM_UNITS(N), .NUM_VOTE(V), .DATA_W(W), .RST_CYCLES(RST)) uut (
    .clk(clk), .rst_n(rst_n), .unit_result(unit_result), .unit_valid(unit_valid),
    .voted_result(voted_result), .voted_valid(voted_valid), .no_majority(no_majority),
    .unit_reset(unit_reset), .active_map(active_map), .degraded(degraded), .alarm(alarm)
  );

  task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] all_same(input logic [W-1:0] x);
    logic [N*W-1:0] r;
    for (int u = 0; u < N; u++) r[u*W +: W] = x;
    return r;
  endfunction

  task automatic model_reset();
    m_act   = N'((1 << V) - 1);
    m_spare = ~m_act;
    m_voted = '0;
    m_degr  = 1'b0;
    for (int u = 0; u < N; u++) m_cnt[u] = 0;
  endtask

  // Driver: applies one cycle of inputs and queues the expected outcome.
  task automatic drive(input logic [N*W-1:0] res, input logic [N-1:0] val);
    exp_t e;
    logic en, tie;
    logic [W-1:0] mj;
    logic [N-1:0] lose;
    int n, ones, need;
    @(negedge clk);
    unit_result = res;
    unit_valid  = val;
    n  = $countones(m_act);
    en = (n > 0);
    for (int u = 0; u < N; u++) if (m_act[u] && !val[u]) en = 1'b0;
    tie = 1'b0;
    mj  = '0;
    for (int b = 0; b < W; b++) begin
      ones = 0;
      for (int u = 0; u < N; u++) if (m_act[u] && res[u*W+b]) ones++;
      if (2*ones > n) mj[b] = 1'b1;
      if (2*ones == n) tie = 1'b1;
    end
    lose = '0;
    if (en && !tie)
      for (int u = 0; u < N; u++) if (m_act[u] && res[u*W +: W] != mj) lose[u] = 1'b1;
    need = $countones(lose);
    m_act = m_act & ~lose;
    for (int u = 0; u < N; u++)
      if (m_spare[u] && need > 0) begin
        m_spare[u] = 1'b0; m_act[u] = 1'b1; need--;
      end
    if (need > 0) m_degr = 1'b1;
    if (en) m_voted = mj;
    for (int u = 0; u < N; u++) begin
      if (lose[u]) m_cnt[u] = RST;
      else if (m_cnt[u] > 0) m_cnt[u]--;
    end
    e.voted = m_voted; e.vvalid = en; e.nomaj = en && tie;
    e.act = m_act; e.degr = m_degr; e.alarm = ($countones(m_act) < 3);
    for (int u = 0; u < N; u++) e.rst[u] = (m_cnt[u] > 0);
    sb.push_back(e);
  endtask

  // Monitor: compares after each edge once outputs have settled.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check("R2", "voted_result", voted_result, e.voted);
        check("R3", "voted_valid", W'(voted_valid), W'(e.vvalid));
        check("R4", "no_majority", W'(no_majority), W'(e.nomaj));
        check("R6", "active_map", W'(active_map), W'(e.act));
        check("R5", "unit_reset", W'(unit_reset), W'(e.rst));
        check("R8", "degraded", W'(degraded), W'(e.degr));
        check("R9", "alarm", W'(alarm), W'(e.alarm));
      end
    end
  end

  task automatic check_reset_state();
    check("R1", "active_map", W'(active_map), W'(N'((1 << V) - 1)));
    check("R1", "voted_result", voted_result, '0);
    check("R1", "flags", W'({voted_valid, no_majority, degraded, alarm}), '0);
    check("R1", "unit_reset", W'(unit_reset), '0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    unit_result = '0;
    unit_valid  = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N*W-1:0] r;
    do_reset();

    // R2: unanimous results of several patterns
    drive(all_same(8'hA5), '1);
    drive(all_same(8'h3C), '1);
    drive(all_same(8'hFF), '1);

    // R5/R6: unit 1 outlier; unit 4 joins as spare
    r = all_same(8'h5A); r[1*W +: W] = 8'h5B;
    drive(r, '1);
    // R5: watch the reset pulse run out with no vote taken (R3)
    for (int k = 0; k < RST + 1; k++) drive(all_same(8'h00), '0);

    // R3: a voting unit without valid blocks the vote even if it disagrees
    r = all_same(8'h11); r[0*W +: W] = 8'hEE;
    drive(r, 6'b111110);
    // R3/R7: retired unit 1 drives garbage without valid, no effect
    r = all_same(8'h22); r[1*W +: W] = 8'hDD;
    drive(r, 6'b111101);

    // R4: tie on a single bit, and on all bits
    r = all_same(8'h40); r[0*W +: W] = 8'h41; r[2*W +: W] = 8'h41;
    drive(r, '1);
    r = all_same(8'h00); r[3*W +: W] = 8'hFF; r[4*W +: W] = 8'hFF;
    drive(r, '1);

    // R6/R8: units 0 and 2 wrong on different bits; one spare left
    r = all_same(8'h77); r[0*W +: W] = 8'h76; r[2*W +: W] = 8'hF7;
    drive(r, '1);
    drive(all_same(8'h99), '1);

    // R9/R8: another fault among three leaves two voters
    r = all_same(8'h0F); r[5*W +: W] = 8'h1F;
    drive(r, '1);
    // R4: with two voters, any disagreement is a tie
    r = all_same(8'hC3); r[4*W +: W] = 8'h3C;
    drive(r, '1);
    drive(all_same(8'h81), '1);
    for (int k = 0; k < RST + 1; k++) drive(all_same(8'h00), '0);

    repeat (3) @(posedge clk);
    #1;
    // R1/R8: a fresh reset clears the sticky state
    do_reset();
    drive(all_same(8'h12), '1);
    repeat (3) @(posedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule